// File: doc/BRIEF.md
# OCP Request Packetizing Network Interface

This block sits between an OCP master port and a wormhole network-on-chip. Each OCP request becomes one request packet on a 64-bit cell stream: a header cell that identifies the packet and where it goes, then an addressing cell with the full target address, then one data cell per write beat. Packets travelling back from the network are turned into OCP read or write responses. Each packet is a header cell followed by the number of data cells that the header states.

The header is assembled in the same cycle the command is presented, so the command is accepted the moment the network can take the header. The memory bank that is the target comes from two address bits. The pressure level on the master's flag input is copied into the header. An exclusive read sends a lock-read packet and locks the path. The next write or non-posted write from this master sends an unlocking packet.

Top module: `ocp_pkt_ni`

## Requirements
- R1: A read produces exactly two request cells, a header and then an addressing cell. A write or non-posted write produces a header, an addressing cell and one data cell per accepted write beat, in that order.
- R2: Header cell layout: bits [63:60] packet type, [59:58] pressure, [57:50] payload length, [49:44] target port, [43:40] source id (parameter SRC_ID), bits [39:0] zero. Type codes: 0 read, 1 write, 2 non-posted write, 3 lock read, 4 response, 5 unlocking write, 6 unlocking non-posted write.
- R3: The target port field holds mAddr[29:28], zero-extended to six bits.
- R4: The pressure field holds the value of mFlag presented with the command.
- R5: The payload length field holds mBurstLen, for reads and for writes.
- R6: The addressing cell holds mAddr zero-extended to 64 bits.
- R7: sCmdAcc is high only in a cycle where the header cell is valid and reqCellReady is high. While the network is not ready, the command is not accepted and no cell is lost.
- R8: sDataAcc is high only when a data cell is handed to the network (reqCellReady high). Data cells carry mData unchanged, in order, and the write burst ends with the beat that has mDataLast set.
- R9: mCmd 3 (exclusive read) sends type 3 and sets the lock. While locked, mCmd 2 (read) sends type 0. The next mCmd 1 (write) sends type 5, or the next mCmd 5 (non-posted write) sends type 6, and that command clears the lock. Later writes send types 1 and 2.
- R10: A response header is consumed with sResp held at 0 (no response). Each response data cell that follows gives one beat with sResp = 1 (data valid) and sData equal to the cell. The beat whose count matches the header length field has sRespLast set. A header with length 0 gives no beat.
- R11: While mRespAcc is low, rspCellReady is low and no response cell is consumed.
- R12: mCmd values 0, 4, 6 and 7 produce no request cell and never raise sCmdAcc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| mCmd | input | 3 | OCP command: 1 write, 2 read, 3 exclusive read, 5 non-posted write |
| mAddr | input | ADDR_W | OCP request address |
| mBurstLen | input | LEN_W | Burst length in beats |
| mData | input | 64 | Write data |
| mDataValid | input | 1 | Write data valid |
| mDataLast | input | 1 | Last write beat of the burst |
| mRespAcc | input | 1 | Master accepts the response |
| mFlag | input | 2 | Pressure level of the request |
| sCmdAcc | output | 1 | Command accepted |
| sDataAcc | output | 1 | Write data accepted |
| sResp | output | 2 | Response code: 0 none, 1 data valid |
| sData | output | 64 | Read response data |
| sRespLast | output | 1 | Last response beat |
| reqCellValid | output | 1 | Request cell valid |
| reqCellReady | input | 1 | Network accepts the request cell |
| reqCell | output | 64 | Request cell |
| rspCellValid | input | 1 | Response cell valid |
| rspCellReady | output | 1 | Response cell accepted |
| rspCell | input | 64 | Response cell |

## Verification
The bench builds the block with SRC_ID set to 4'hA, so the source field is a non-zero value that can be told apart from the zero padding next to it. It keeps the default 32-bit address, a bank select at bits 29:28 and 8-bit burst lengths, so that addresses in banks 0 to 3 place every target code in the header. A periodic stall on the request ready and on the response accept lets a three-beat write and a three-beat read response both pass through cycles where they are held. A chain of exclusive read, locked read, unlocking write, plain write and unlocking non-posted write exercises every transition of the lock state.

// File: rtl/ocp_pkt_pkg.sv
package ocp_pkt_pkg;

  localparam int CELL_W = 64;

  // OCP command codes
  localparam logic [2:0] CMD_IDLE = 3'd0;
  localparam logic [2:0] CMD_WR   = 3'd1;
  localparam logic [2:0] CMD_RD   = 3'd2;
  localparam logic [2:0] CMD_RDEX = 3'd3;
  localparam logic [2:0] CMD_WRNP = 3'd5;

  // OCP response codes
  localparam logic [1:0] RESP_NULL = 2'd0;
  localparam logic [1:0] RESP_DVA  = 2'd1;

  // header field positions used by the response side
  localparam int LEN_FLD_LSB = 50;
  localparam int LEN_FLD_W   = 8;
  localparam int TGT_FLD_W   = 6;

  typedef enum logic [3:0] {
    PT_READ      = 4'd0,
    PT_WRITE     = 4'd1,
    PT_WRNP      = 4'd2,
    PT_LOCKRD    = 4'd3,
    PT_RESP      = 4'd4,
    PT_UNLK_WR   = 4'd5,
    PT_UNLK_WRNP = 4'd6
  } pktType_e;

  typedef enum logic [1:0] {
    SEL_HDR  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2
  } cellSel_e;

  typedef struct packed {
    cellSel_e reqSel;   // which request cell drives the output
    logic     hdrTake;  // header handed to the network this cycle
    logic     rspLoad;  // response header consumed: load beat count
    logic     rspTake;  // response data cell consumed
    logic     rspBeat;  // a response data cell is presented to the master
  } niStrobe_t;

  function automatic logic [CELL_W-1:0] mkHeader(
    input pktType_e             kind,
    input logic [1:0]           press,
    input logic [LEN_FLD_W-1:0] len,
    input logic [TGT_FLD_W-1:0] tgt,
    input logic [3:0]           src
  );
    mkHeader = {kind, press, len, tgt, src, 40'd0};
  endfunction

endpackage

// File: rtl/ocp_pkt_ctrl.sv
module ocp_pkt_ctrl
  import ocp_pkt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] mCmd,
  input  logic       mDataValid,
  input  logic       mDataLast,
  input  logic       reqCellReady,
  input  logic       rspCellValid,
  input  logic       mRespAcc,
  input  logic       rspLastBeat,
  input  logic       rspLenZero,
  output niStrobe_t  stb,
  output logic       reqCellValid,
  output logic       sCmdAcc,
  output logic       sDataAcc,
  output logic       rspCellReady,
  output logic       lockActive
);

  typedef enum logic [1:0] {RQ_IDLE, RQ_ADDR, RQ_DATA} rqState_e;
  typedef enum logic {RS_HDR, RS_DATA} rsState_e;

  rqState_e rqState, rqNext;
  rsState_e rsState, rsNext;
  logic     wrQ;
  logic     lockQ;
  logic     cmdKnown;
  logic     cmdIsWr;

  assign cmdIsWr  = (mCmd == CMD_WR) || (mCmd == CMD_WRNP);
  assign cmdKnown = cmdIsWr || (mCmd == CMD_RD) || (mCmd == CMD_RDEX);
  assign lockActive = lockQ;
  assign rspCellReady = mRespAcc;

  // request packet sequencing
  always_comb begin
    stb.reqSel  = SEL_HDR;
    stb.hdrTake = 1'b0;
    reqCellValid = 1'b0;
    sCmdAcc  = 1'b0;
    sDataAcc = 1'b0;
    rqNext   = rqState;
    case (rqState)
      RQ_IDLE: begin
        reqCellValid = cmdKnown;
        sCmdAcc      = cmdKnown && reqCellReady;
        stb.hdrTake  = cmdKnown && reqCellReady;
        if (cmdKnown && reqCellReady) rqNext = RQ_ADDR;
      end
      RQ_ADDR: begin
        stb.reqSel   = SEL_ADDR;
        reqCellValid = 1'b1;
        if (reqCellReady) rqNext = wrQ ? RQ_DATA : RQ_IDLE;
      end
      RQ_DATA: begin
        stb.reqSel   = SEL_DATA;
        reqCellValid = mDataValid;
        sDataAcc     = mDataValid && reqCellReady;
        if (mDataValid && reqCellReady && mDataLast) rqNext = RQ_IDLE;
      end
      default: rqNext = RQ_IDLE;
    endcase
  end

  // response depacketizing
  always_comb begin
    stb.rspLoad = 1'b0;
    stb.rspTake = 1'b0;
    stb.rspBeat = 1'b0;
    rsNext = rsState;
    case (rsState)
      RS_HDR: begin
        if (rspCellValid && mRespAcc) begin
          stb.rspLoad = 1'b1;
          if (!rspLenZero) rsNext = RS_DATA;
        end
      end
      RS_DATA: begin
        stb.rspBeat = rspCellValid;
        stb.rspTake = rspCellValid && mRespAcc;
        if (rspCellValid && mRespAcc && rspLastBeat) rsNext = RS_HDR;
      end
      default: rsNext = RS_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rqState <= RQ_IDLE;
      rsState <= RS_HDR;
      wrQ     <= 1'b0;
      lockQ   <= 1'b0;
    end else begin
      rqState <= rqNext;
      rsState <= rsNext;
      if (stb.hdrTake) begin
        wrQ <= cmdIsWr;
        if (mCmd == CMD_RDEX) lockQ <= 1'b1;
        else if (cmdIsWr)     lockQ <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ocp_pkt_dp.sv
module ocp_pkt_dp
  import ocp_pkt_pkg::*;
#(
  parameter int         ADDR_W  = 32,
  parameter int         TGT_LSB = 28,
  parameter int         TGT_W   = 2,
  parameter int         LEN_W   = 8,
  parameter logic [3:0] SRC_ID  = 4'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  niStrobe_t         stb,
  input  logic              lockActive,
  input  logic [2:0]        mCmd,
  input  logic [ADDR_W-1:0] mAddr,
  input  logic [LEN_W-1:0]  mBurstLen,
  input  logic [CELL_W-1:0] mData,
  input  logic [1:0]        mFlag,
  input  logic [CELL_W-1:0] rspCell,
  output logic [CELL_W-1:0] reqCell,
  output logic [1:0]        sResp,
  output logic [CELL_W-1:0] sData,
  output logic              sRespLast,
  output logic              rspLastBeat,
  output logic              rspLenZero
);

  logic [ADDR_W-1:0]    addrQ;
  logic [CELL_W-1:0]    hdrCell;
  logic [TGT_FLD_W-1:0] tgtField;
  logic [LEN_FLD_W-1:0] lenField;
  logic [LEN_FLD_W-1:0] rspLen;
  logic [LEN_FLD_W-1:0] rspCnt;
  pktType_e             pktType;

  // field widening chosen by parameters
  generate
    if (TGT_W == TGT_FLD_W) begin : g_tgtFull
      assign tgtField = mAddr[TGT_LSB +: TGT_W];
    end else begin : g_tgtPad
      assign tgtField = {{(TGT_FLD_W-TGT_W){1'b0}}, mAddr[TGT_LSB +: TGT_W]};
    end
    if (LEN_W == LEN_FLD_W) begin : g_lenFull
      assign lenField = mBurstLen;
    end else begin : g_lenPad
      assign lenField = {{(LEN_FLD_W-LEN_W){1'b0}}, mBurstLen};
    end
  endgenerate

  always_comb begin
    case (mCmd)
      CMD_RDEX: pktType = PT_LOCKRD;
      CMD_WR:   pktType = lockActive ? PT_UNLK_WR : PT_WRITE;
      CMD_WRNP: pktType = lockActive ? PT_UNLK_WRNP : PT_WRNP;
      default:  pktType = PT_READ;
    endcase
  end

  assign hdrCell = mkHeader(pktType, mFlag, lenField, tgtField, SRC_ID);

  always_comb begin
    case (stb.reqSel)
      SEL_ADDR: reqCell = {{(CELL_W-ADDR_W){1'b0}}, addrQ};
      SEL_DATA: reqCell = mData;
      default:  reqCell = hdrCell;
    endcase
  end

  assign rspLen      = rspCell[LEN_FLD_LSB +: LEN_FLD_W];
  assign rspLenZero  = (rspLen == '0);
  assign rspLastBeat = (rspCnt == LEN_FLD_W'(1));
  assign sData       = rspCell;
  assign sResp       = stb.rspBeat ? RESP_DVA : RESP_NULL;
  assign sRespLast   = stb.rspBeat && rspLastBeat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      rspCnt <= '0;
    end else begin
      if (stb.hdrTake) addrQ <= mAddr;
      if (stb.rspLoad)      rspCnt <= rspLen;
      else if (stb.rspTake) rspCnt <= rspCnt - LEN_FLD_W'(1);
    end
  end

endmodule

// File: rtl/ocp_pkt_ni.sv
module ocp_pkt_ni
  import ocp_pkt_pkg::*;
#(
  parameter int         ADDR_W  = 32,
  parameter int         TGT_LSB = 28,
  parameter int         TGT_W   = 2,
  parameter int         LEN_W   = 8,
  parameter logic [3:0] SRC_ID  = 4'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        mCmd,
  input  logic [ADDR_W-1:0] mAddr,
  input  logic [LEN_W-1:0]  mBurstLen,
  input  logic [63:0]       mData,
  input  logic              mDataValid,
  input  logic              mDataLast,
  input  logic              mRespAcc,
  input  logic [1:0]        mFlag,
  output logic              sCmdAcc,
  output logic              sDataAcc,
  output logic [1:0]        sResp,
  output logic [63:0]       sData,
  output logic              sRespLast,
  output logic              reqCellValid,
  input  logic              reqCellReady,
  output logic [63:0]       reqCell,
  input  logic              rspCellValid,
  output logic              rspCellReady,
  input  logic [63:0]       rspCell
);

  niStrobe_t stb;
  logic      lockActive;
  logic      rspLastBeat;
  logic      rspLenZero;

  ocp_pkt_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .mCmd         (mCmd),
    .mDataValid   (mDataValid),
    .mDataLast    (mDataLast),
    .reqCellReady (reqCellReady),
    .rspCellValid (rspCellValid),
    .mRespAcc     (mRespAcc),
    .rspLastBeat  (rspLastBeat),
    .rspLenZero   (rspLenZero),
    .stb          (stb),
    .reqCellValid (reqCellValid),
    .sCmdAcc      (sCmdAcc),
    .sDataAcc     (sDataAcc),
    .rspCellReady (rspCellReady),
    .lockActive   (lockActive)
  );

  ocp_pkt_dp #(
    .ADDR_W  (ADDR_W),
    .TGT_LSB (TGT_LSB),
    .TGT_W   (TGT_W),
    .LEN_W   (LEN_W),
    .SRC_ID  (SRC_ID)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .lockActive  (lockActive),
    .mCmd        (mCmd),
    .mAddr       (mAddr),
    .mBurstLen   (mBurstLen),
    .mData       (mData),
    .mFlag       (mFlag),
    .rspCell     (rspCell),
    .reqCell     (reqCell),
    .sResp       (sResp),
    .sData       (sData),
    .sRespLast   (sRespLast),
    .rspLastBeat (rspLastBeat),
    .rspLenZero  (rspLenZero)
  );

endmodule

// File: rtl/ocp_pkt_chk.sv
module ocp_pkt_chk
  import ocp_pkt_pkg::*;
#(
  parameter int         ADDR_W = 32,
  parameter int         LEN_W  = 8,
  parameter logic [3:0] SRC_ID = 4'h0
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        mCmd,
  input logic [ADDR_W-1:0] mAddr,
  input logic [LEN_W-1:0]  mBurstLen,
  input logic [63:0]       mData,
  input logic              mDataValid,
  input logic              mDataLast,
  input logic              mRespAcc,
  input logic [1:0]        mFlag,
  input logic              sCmdAcc,
  input logic              sDataAcc,
  input logic [1:0]        sResp,
  input logic [63:0]       sData,
  input logic              sRespLast,
  input logic              reqCellValid,
  input logic              reqCellReady,
  input logic [63:0]       reqCell,
  input logic              rspCellValid,
  input logic              rspCellReady,
  input logic [63:0]       rspCell
);

  AST_HDR_ACC_READY: assert property (@(posedge clk) disable iff (!rstN)
    sCmdAcc |-> (reqCellValid && reqCellReady)); // R7

  AST_DATA_ACC_READY: assert property (@(posedge clk) disable iff (!rstN)
    sDataAcc |-> (reqCellValid && reqCellReady)); // R8

  AST_ACC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(sCmdAcc && sDataAcc)); // R8

  AST_ADDR_FOLLOWS_HDR: assert property (@(posedge clk) disable iff (!rstN)
    sCmdAcc |=> (reqCellValid && !sCmdAcc && !sDataAcc)); // R1

  AST_HDR_SRC_PAD: assert property (@(posedge clk) disable iff (!rstN)
    sCmdAcc |-> (reqCell[43:40] == SRC_ID && reqCell[39:0] == 40'd0)); // R2

  AST_RSP_STALL: assert property (@(posedge clk) disable iff (!rstN)
    !mRespAcc |-> !rspCellReady); // R11

  AST_LAST_IS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    sRespLast |-> (sResp == RESP_DVA)); // R10

  AST_IDLE_CMD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (mCmd == CMD_IDLE) |-> !sCmdAcc); // R12

endmodule

bind ocp_pkt_ni ocp_pkt_chk #(
  .ADDR_W (ADDR_W),
  .LEN_W  (LEN_W),
  .SRC_ID (SRC_ID)
) i_chk (.*);

// File: tb/test_ocp_pkt_ni.sv
module test_ocp_pkt_ni;

  localparam logic [3:0] SRC = 4'hA;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  mCmd = 3'd0;
  logic [31:0] mAddr = '0;
  logic [7:0]  mBurstLen = '0;
  logic [63:0] mData = '0;
  logic        mDataValid = 1'b0;
  logic        mDataLast = 1'b0;
  logic        mRespAcc = 1'b0;
  logic [1:0]  mFlag = '0;
  logic        sCmdAcc, sDataAcc, sRespLast, reqCellValid, rspCellReady;
  logic [1:0]  sResp;
  logic [63:0] sData, reqCell;
  logic        reqCellReady = 1'b1;
  logic        rspCellValid = 1'b0;
  logic [63:0] rspCell = '0;

  int nChk = 0;
  int nBad = 0;
  int cyc = 0;
  bit reqStall = 0;
  bit rspStall = 0;
  bit rspOn = 0;

  logic [63:0] reqLog [0:31];
  int          reqN = 0;
  logic [63:0] rLogD [0:15];
  logic        rLogL [0:15];
  int          rN = 0;

  always #2 clk = ~clk;

  ocp_pkt_ni #(.SRC_ID(SRC)) i_ocp_pkt_ni (
    .clk(clk), .rstN(rstN), .mCmd(mCmd), .mAddr(mAddr), .mBurstLen(mBurstLen),
    .mData(mData), .mDataValid(mDataValid), .mDataLast(mDataLast),
    .mRespAcc(mRespAcc), .mFlag(mFlag), .sCmdAcc(sCmdAcc), .sDataAcc(sDataAcc),
    .sResp(sResp), .sData(sData), .sRespLast(sRespLast),
    .reqCellValid(reqCellValid), .reqCellReady(reqCellReady), .reqCell(reqCell),
    .rspCellValid(rspCellValid), .rspCellReady(rspCellReady), .rspCell(rspCell)
  );

  // network and master acceptance patterns
  always @(negedge clk) begin
    cyc <= cyc + 1;
    reqCellReady <= reqStall ? (cyc % 3 != 1) : 1'b1;
    mRespAcc <= rspOn && (rspStall ? (cyc % 2 == 0) : 1'b1);
  end

  // log every handshake, sampled mid-cycle
  always @(negedge clk) begin
    #2;
    if (reqCellValid && reqCellReady && reqN < 32) begin
      reqLog[reqN] = reqCell;
      reqN++;
    end
    if (sResp == 2'd1 && mRespAcc && rN < 16) begin
      rLogD[rN] = sData;
      rLogL[rN] = sRespLast;
      rN++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] hdr(input logic [3:0] t, input logic [1:0] p,
                                      input logic [7:0] l, input logic [5:0] tg);
    return {t, p, l, tg, SRC, 40'd0};
  endfunction

  task automatic issue(input logic [2:0] cmd, input logic [31:0] addr, input logic [1:0] fl,
                       input logic [7:0] len, input logic [63:0] seed);
    bit done;
    @(negedge clk);
    mCmd = cmd; mAddr = addr; mFlag = fl; mBurstLen = len;
    done = 0;
    while (!done) begin
      #1;
      if (reqCellValid && !reqCellReady) chk("R7 no accept while stalled", {63'd0, sCmdAcc}, 64'd0);
      done = sCmdAcc;
      @(negedge clk);
    end
    mCmd = 3'd0;
    if (cmd == 3'd1 || cmd == 3'd5) begin
      for (int i = 0; i < len; i++) begin
        mData = seed + 64'(i); mDataValid = 1'b1; mDataLast = (i == len - 1);
        done = 0;
        while (!done) begin
          #1;
          done = sDataAcc;
          @(negedge clk);
        end
      end
      mDataValid = 1'b0; mDataLast = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic sendRsp(input logic [63:0] c, input bit isHdr);
    bit done;
    rspCellValid = 1'b1; rspCell = c;
    done = 0;
    while (!done) begin
      #1;
      if (!mRespAcc) chk("R11 not ready while master stalls", {63'd0, rspCellReady}, 64'd0);
      if (isHdr) chk("R10 header gives no beat", {62'd0, sResp}, 64'd0);
      done = rspCellReady;
      @(negedge clk);
    end
    rspCellValid = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk); #1;
    chk("R7 reset valid", {63'd0, reqCellValid}, 64'd0);
    chk("R7 reset cmd accept", {63'd0, sCmdAcc}, 64'd0);
    chk("R8 reset data accept", {63'd0, sDataAcc}, 64'd0);
    chk("R10 reset resp", {62'd0, sResp}, 64'd0);
    chk("R11 reset rsp ready", {63'd0, rspCellReady}, 64'd0);
  endtask

  task automatic testRead();
    reqN = 0;
    issue(3'd2, 32'h2000_1234, 2'd2, 8'd4, 64'd0);
    chk("R1 read cell count", 64'(reqN), 64'd2);
    chk("R2 R3 R4 R5 read header", reqLog[0], hdr(4'd0, 2'd2, 8'd4, 6'd2));
    chk("R6 read address cell", reqLog[1], 64'h0000_0000_2000_1234);
  endtask

  task automatic testWrite();
    reqStall = 1;
    reqN = 0;
    issue(3'd1, 32'h3000_00F0, 2'd1, 8'd3, 64'hA5A5_0000_0000_0010);
    reqStall = 0;
    chk("R1 write cell count", 64'(reqN), 64'd5);
    chk("R2 R3 R5 write header", reqLog[0], hdr(4'd1, 2'd1, 8'd3, 6'd3));
    chk("R6 write address cell", reqLog[1], 64'h0000_0000_3000_00F0);
    for (int i = 0; i < 3; i++)
      chk("R8 write data cell", reqLog[2 + i], 64'hA5A5_0000_0000_0010 + 64'(i));
  endtask

  task automatic testIgnore();
    logic [2:0] bad [0:3];
    bad[0] = 3'd0; bad[1] = 3'd4; bad[2] = 3'd6; bad[3] = 3'd7;
    reqN = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      mCmd = bad[k];
      repeat (2) begin
        #1;
        chk("R12 no cell for unused command", {62'd0, reqCellValid, sCmdAcc}, 64'd0);
        @(negedge clk);
      end
    end
    mCmd = 3'd0;
    repeat (2) @(negedge clk);
    chk("R12 nothing logged", 64'(reqN), 64'd0);
  endtask

  task automatic testLock();
    reqN = 0;
    issue(3'd3, 32'h1000_0040, 2'd3, 8'd1, 64'd0);
    issue(3'd2, 32'h1000_0048, 2'd0, 8'd1, 64'd0);
    issue(3'd1, 32'h1000_0040, 2'd3, 8'd1, 64'h77);
    issue(3'd1, 32'h0000_0000, 2'd0, 8'd1, 64'h88);
    issue(3'd3, 32'h1000_0040, 2'd0, 8'd1, 64'd0);
    issue(3'd5, 32'h1000_0040, 2'd0, 8'd2, 64'h99);
    chk("R9 lock sequence cell count", 64'(reqN), 64'd16);
    chk("R9 lock read header", reqLog[0], hdr(4'd3, 2'd3, 8'd1, 6'd1));
    chk("R9 read while locked", 64'(reqLog[2][63:60]), 64'd0);
    chk("R9 unlocking write", 64'(reqLog[4][63:60]), 64'd5);
    chk("R9 plain write after unlock", reqLog[7], hdr(4'd1, 2'd0, 8'd1, 6'd0));
    chk("R9 second lock read", 64'(reqLog[10][63:60]), 64'd3);
    chk("R9 unlocking non-posted write", 64'(reqLog[12][63:60]), 64'd6);
    chk("R8 non-posted data", reqLog[15], 64'h9A);
  endtask

  task automatic testResp();
    rspOn = 1; rspStall = 1;
    rN = 0;
    @(negedge clk);
    sendRsp(hdr(4'd4, 2'd0, 8'd3, 6'd0), 1);
    sendRsp(64'h1111_2222_3333_4444, 0);
    sendRsp(64'h5555_6666_7777_8888, 0);
    sendRsp(64'h9999_AAAA_BBBB_CCCC, 0);
    sendRsp(hdr(4'd4, 2'd0, 8'd0, 6'd0), 1);
    sendRsp(hdr(4'd4, 2'd0, 8'd1, 6'd0), 1);
    sendRsp(64'hDEAD_BEEF_0000_0001, 0);
    repeat (3) @(negedge clk);
    chk("R10 beat count", 64'(rN), 64'd4);
    chk("R10 beat 0 data", rLogD[0], 64'h1111_2222_3333_4444);
    chk("R10 beat 2 data", rLogD[2], 64'h9999_AAAA_BBBB_CCCC);
    chk("R10 beat 3 data", rLogD[3], 64'hDEAD_BEEF_0000_0001);
    chk("R10 last flags", {60'd0, rLogL[0], rLogL[1], rLogL[2], rLogL[3]}, 64'b0011);
    rspOn = 0; rspStall = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRead();
    testWrite();
    testIgnore();
    testLock();
    testResp();
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule